// File: doc/BRIEF.md
# Oversampled Serial Receiver with Two-Entry Receive Queue

This block receives asynchronous serial frames on a single line. A frame is one start bit, eight or nine data bits sent least significant bit first, and one stop bit. The receiver counts a sample tick that runs at sixteen times the bit rate. It recovers each bit from three samples taken around the middle of the bit. A completed frame moves from the shift register into a two-entry queue. Each queue entry keeps the data byte, the ninth bit and a framing-error flag together.

The consumer takes data through a valid/ready output. `out_valid_o` is high while the queue holds an entry. The head word and its status (`out_bit9_o`, `out_ferr_o`) stay stable until the cycle in which `out_ready_i` is high while `out_valid_o` is high. That cycle pops the entry. Back-pressure never stalls the serial line, because the line cannot be paused. A frame that completes while both entries are occupied and no pop is taking place is dropped. The sticky overrun flag is then set, and reception stops until the enable input is driven low. The status outputs describe only the head entry, so the consumer must read them before it pops.

Top module: `rxf_uart_rx`

## Requirements
- R1: With `mode9_i`=0, a frame of one low start bit, 8 data bits (LSB first) and a stop bit appears in the queue with the byte on `out_data_o` and `out_bit9_o`=0.
- R2: With `mode9_i`=1, nine data bits are received. The ninth received bit is presented on `out_bit9_o`.
- R3: A stop bit decided as 0 stores the frame with `out_ferr_o`=1. A stop bit decided as 1 stores it with `out_ferr_o`=0.
- R4: Sample 0 is the first tick that sees the line low in idle. Every data and stop bit is decided by a majority of its samples 7, 8 and 9, so one corrupted sample among those three does not change the decided value.
- R5: If the line is high at sample 8 of the start bit, the receiver returns to idle and stores nothing.
- R6: The queue holds two entries. The head data and status stay stable while `out_valid_o`=1 and `out_ready_i`=0. A pop presents the next entry with that entry's own ninth bit and framing flag.
- R7: If a stop bit is decided while both entries are occupied and no pop happens in that cycle, `overrun_o` is set and the frame is discarded. While `overrun_o`=1 no further frame is stored. `overrun_o` clears only while `en_i`=0.
- R8: If a pop happens in the same cycle as a stop decision on a full queue, the new frame is stored behind the remaining entry and `overrun_o` stays 0.
- R9: `rx_ready_o` is 1 exactly while the queue is non-empty. `irq_o` is `rx_ready_o` AND `irq_en_i`.
- R10: Driving `en_i` low aborts a frame in progress, so no partial frame is stored. `out_ready_i` asserted while the queue is empty has no effect.
- R11: After reset the queue is empty and `overrun_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| en_i | input | 1 | Receive enable; low resets the receive logic and overrun |
| mode9_i | input | 1 | 1 selects nine data bits |
| irq_en_i | input | 1 | Interrupt mask |
| out_ready_i | input | 1 | Consumer accepts the head entry |
| out_valid_o | output | 1 | Head entry present |
| out_data_o | output | 8 | Head data byte |
| out_bit9_o | output | 1 | Head ninth bit |
| out_ferr_o | output | 1 | Head framing error |
| rx_ready_o | output | 1 | Queue non-empty |
| irq_o | output | 1 | Masked receive interrupt |
| overrun_o | output | 1 | Sticky overrun |

## Verification
Two functions can fall in the same cycle: the stop-bit decision that writes into a full queue, and a consumer pop. The bench drives the sample tick itself. It raises `out_ready_i` on exactly the tick that carries sample 9 of the third frame's stop bit. The check passes if `overrun_o` stays low and the two following pops return the second and third frames in order. A separate run without that pop must set overrun and keep the first two frames unchanged.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rxf_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rxf_framer.sv
module rxf_framer
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_i,
  input  logic            tick_i,
  input  logic            rx_i,
  input  logic            mode9_i,
  output logic            done_o,
  output logic [DATA_W:0] word_o,
  output logic            ferr_o
);
  localparam int CNT_W  = $clog2(OS);
  localparam int BIDX_W = $clog2(DATA_W + 1);
  localparam int MID    = OS / 2;
  localparam logic [CNT_W-1:0] S_LO  = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] S_MID = CNT_W'(MID);
  localparam logic [CNT_W-1:0] S_HI  = CNT_W'(MID + 1);
  localparam logic [CNT_W-1:0] S_END = CNT_W'(OS - 1);

  rxf_state_t         state;
  logic [CNT_W-1:0]   scnt;
  logic [BIDX_W-1:0]  bidx;
  logic [DATA_W:0]    shreg;
  logic [1:0]         smp;
  logic               vote;
  logic [BIDX_W-1:0]  last_idx;
  logic [CNT_W-1:0]   scnt_inc;

  assign vote     = maj3(smp[0], smp[1], rx_i);
  assign last_idx = mode9_i ? BIDX_W'(DATA_W) : BIDX_W'(DATA_W - 1);
  assign scnt_inc = (scnt == S_END) ? '0 : scnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      scnt  <= '0;
      bidx  <= '0;
      shreg <= '0;
      smp   <= '0;
    end else if (hold_i) begin
      state <= ST_IDLE;
      scnt  <= '0;
      bidx  <= '0;
    end else if (tick_i) begin
      if (state == ST_IDLE) begin
        if (!rx_i) begin
          state <= ST_START;
          scnt  <= CNT_W'(1);
        end
      end else begin
        scnt <= scnt_inc;
        if (scnt == S_LO)  smp[0] <= rx_i;
        if (scnt == S_MID) smp[1] <= rx_i;
        case (state)
          ST_START: begin
            if (scnt == S_MID && rx_i) begin
              state <= ST_IDLE;
              scnt  <= '0;
            end else if (scnt == S_END) begin
              state <= ST_DATA;
              bidx  <= '0;
            end
          end
          ST_DATA: begin
            if (scnt == S_HI) shreg <= {vote, shreg[DATA_W:1]};
            if (scnt == S_END) begin
              if (bidx == last_idx) state <= ST_STOP;
              else                  bidx  <= bidx + 1'b1;
            end
          end
          ST_STOP: begin
            if (scnt == S_HI) begin
              state <= ST_IDLE;
              scnt  <= '0;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o = tick_i && !hold_i && (state == ST_STOP) && (scnt == S_HI);
  assign word_o = mode9_i ? shreg : {1'b0, shreg[DATA_W:1]};
  assign ferr_o = ~vote;
endmodule

// File: rtl/rxf_fifo.sv
module rxf_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic [W-1:0]               din_i,
  input  logic                       pop_i,
  output logic [W-1:0]               dout_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_pop;

  assign do_pop = pop_i && (count != '0);

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_i) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_i, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout_o  = mem[rd_ptr];
  assign count_o = count;
endmodule

// File: rtl/rxf_uart_rx.sv
module rxf_uart_rx #(
  parameter int DATA_W      = 8,
  parameter int OS          = 16,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              mode9_i,
  input  logic              irq_en_i,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_bit9_o,
  output logic              out_ferr_o,
  output logic              rx_ready_o,
  output logic              irq_o,
  output logic              overrun_o
);
  localparam int ENT_W = DATA_W + 2;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic             rx_s;
  logic             hold;
  logic             done;
  logic [DATA_W:0]  word;
  logic             ferr;
  logic             pop, push, full;
  logic [ENT_W-1:0] head;
  logic [CNT_W-1:0] fifo_cnt;
  logic             overrun;

  rxf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s)
  );

  assign hold = !en_i || overrun;

  rxf_framer #(.DATA_W(DATA_W), .OS(OS)) u_framer (
    .clk(clk), .rst_n(rst_n), .hold_i(hold), .tick_i(tick_i), .rx_i(rx_s),
    .mode9_i(mode9_i), .done_o(done), .word_o(word), .ferr_o(ferr)
  );

  assign full = (fifo_cnt == FULL_CNT);
  assign pop  = out_valid_o && out_ready_i;
  assign push = done && (!full || pop);

  rxf_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(push), .din_i({ferr, word}),
    .pop_i(pop), .dout_o(head), .count_o(fifo_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     overrun <= 1'b0;
    else if (!en_i)                 overrun <= 1'b0;
    else if (done && full && !pop)  overrun <= 1'b1;
  end

  assign out_valid_o = (fifo_cnt != '0);
  assign out_data_o  = head[DATA_W-1:0];
  assign out_bit9_o  = head[DATA_W];
  assign out_ferr_o  = head[DATA_W+1];
  assign rx_ready_o  = out_valid_o;
  assign irq_o       = out_valid_o && irq_en_i;
  assign overrun_o   = overrun;
endmodule

// File: rtl/rxf_uart_rx_chk.sv
module rxf_uart_rx_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       en_i,
  input logic                       irq_en_i,
  input logic                       out_ready_i,
  input logic                       out_valid_o,
  input logic [DATA_W-1:0]          out_data_o,
  input logic                       out_bit9_o,
  input logic                       out_ferr_o,
  input logic                       irq_o,
  input logic                       overrun_o,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  p_depth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= FULL_CNT);

  p_head_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
      && $stable(out_bit9_o) && $stable(out_ferr_o));

  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && overrun_o |=> overrun_o);

  p_ovr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !overrun_o);

  p_ovr_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o && !out_valid_o |=> !out_valid_o);

  p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> !irq_o);

  p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid_o && out_ready_i |=> fifo_cnt <= CNT_W'(1));
endmodule

bind rxf_uart_rx rxf_uart_rx_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .irq_en_i(irq_en_i),
  .out_ready_i(out_ready_i), .out_valid_o(out_valid_o),
  .out_data_o(out_data_o), .out_bit9_o(out_bit9_o), .out_ferr_o(out_ferr_o),
  .irq_o(irq_o), .overrun_o(overrun_o), .fifo_cnt(fifo_cnt)
);

// File: tb/test_rxf_uart_rx.sv
`timescale 1ns/1ps
module test_rxf_uart_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1, tick = 1'b0, en = 1'b0, mode9 = 1'b0, irq_en = 1'b0, rdy = 1'b0;
  logic       valid, bit9, ferr, rxr, irq, ovr;
  logic [7:0] data;
  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rxf_uart_rx i_rxf_uart_rx (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick), .en_i(en),
    .mode9_i(mode9), .irq_en_i(irq_en), .out_ready_i(rdy),
    .out_valid_o(valid), .out_data_o(data), .out_bit9_o(bit9),
    .out_ferr_o(ferr), .rx_ready_o(rxr), .irq_o(irq), .overrun_o(ovr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one sample: line value held, tick pulsed on the third cycle (starts at a negedge)
  task automatic sample(input logic v, input logic pop_now);
    rx = v; tick = 1'b0; rdy = 1'b0;
    @(negedge clk);
    @(negedge clk);
    tick = 1'b1; rdy = pop_now;
    @(negedge clk);
    tick = 1'b0; rdy = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) sample(1'b1, 1'b0);
  endtask

  task automatic send(input logic [8:0] w, input logic m9, input logic stopv,
                      input logic pop_at_stop, input int gbit, input int gsmp);
    int nb;
    logic val;
    nb = m9 ? 9 : 8;
    for (int b = 0; b <= nb + 1; b++) begin
      if (b == 0)       val = 1'b0;
      else if (b <= nb) val = w[b-1];
      else              val = stopv;
      for (int s = 0; s < 16; s++)
        sample((b == gbit && s == gsmp) ? ~val : val,
               pop_at_stop && (b == nb + 1) && (s == 9));
    end
    idle(stopv ? 1 : 16);
  endtask

  task automatic pop1;
    rdy = 1'b1;
    @(negedge clk);
    rdy = 1'b0;
  endtask

  task automatic toggle_en;
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R11 watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [8:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 valid after reset", valid, 0);
    chk("R11 overrun after reset", ovr, 0);
    chk("R11 irq after reset", irq, 0);
    en = 1'b1;
    @(negedge clk);

    // R10: ready on empty queue has no effect
    pop1();
    chk("R10 ready on empty", valid, 0);

    // R1: 8-bit sweep
    for (int i = 0; i < 98; i++) begin
      v = (i == 96) ? 8'h00 : (i == 97) ? 8'hFF : 8'((i * 73 + 5) & 255);
      send({1'b0, v}, 1'b0, 1'b1, 1'b0, -1, 0);
      chk("R1 valid", valid, 1);
      chk("R1 data", data, v);
      chk("R1 bit9 zero", bit9, 0);
      chk("R3 ferr clear", ferr, 0);
      pop1();
      chk("R9 empty after pop", rxr, 0);
    end

    // R2: 9-bit sweep
    mode9 = 1'b1;
    for (int i = 0; i < 32; i++) begin
      w = 9'((i * 151 + 3) & 511);
      send(w, 1'b1, 1'b1, 1'b0, -1, 0);
      chk("R2 data", data, w[7:0]);
      chk("R2 bit9", bit9, w[8]);
      pop1();
    end
    mode9 = 1'b0;

    // R3: framing error per entry, R6 status follows the entry
    send(9'h05A, 1'b0, 1'b0, 1'b0, -1, 0);
    send(9'h03C, 1'b0, 1'b1, 1'b0, -1, 0);
    chk("R3 ferr set", ferr, 1);
    chk("R3 data kept", data, 8'h5A);
    pop1();
    chk("R6 next data", data, 8'h3C);
    chk("R6 next ferr", ferr, 0);
    pop1();

    // R4: single corrupted vote sample
    send(9'h0A5, 1'b0, 1'b1, 1'b0, 1, 8);
    chk("R4 glitch s8", data, 8'hA5);
    pop1();
    send(9'h0A5, 1'b0, 1'b1, 1'b0, 4, 7);
    chk("R4 glitch s7", data, 8'hA5);
    pop1();
    send(9'h0A5, 1'b0, 1'b1, 1'b0, 9, 9);
    chk("R4 glitch stop s9", ferr, 0);
    pop1();

    // R5: false start
    for (int s = 0; s < 8; s++) sample(1'b0, 1'b0);
    for (int s = 0; s < 8; s++) sample(1'b1, 1'b0);
    idle(16);
    chk("R5 false start", valid, 0);
    send(9'h081, 1'b0, 1'b1, 1'b0, -1, 0);
    chk("R5 recover", data, 8'h81);
    pop1();

    // R9: interrupt mask
    send(9'h011, 1'b0, 1'b1, 1'b0, -1, 0);
    irq_en = 1'b0;
    @(negedge clk);
    chk("R9 irq masked", irq, 0);
    chk("R9 ready flag", rxr, 1);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R9 irq enabled", irq, 1);
    pop1();
    chk("R9 irq after drain", irq, 0);

    // R7: overrun
    send(9'h0A1, 1'b0, 1'b1, 1'b0, -1, 0);
    send(9'h0B2, 1'b0, 1'b1, 1'b0, -1, 0);
    chk("R7 no overrun at two", ovr, 0);
    send(9'h0C3, 1'b0, 1'b1, 1'b0, -1, 0);
    chk("R7 overrun set", ovr, 1);
    chk("R7 head kept", data, 8'hA1);
    send(9'h0D4, 1'b0, 1'b1, 1'b0, -1, 0);
    pop1();
    chk("R7 second kept", data, 8'hB2);
    pop1();
    chk("R7 dropped words", valid, 0);
    send(9'h0E5, 1'b0, 1'b1, 1'b0, -1, 0);
    chk("R7 frozen", valid, 0);
    chk("R7 still set", ovr, 1);
    toggle_en();
    chk("R7 cleared by enable", ovr, 0);
    send(9'h0F6, 1'b0, 1'b1, 1'b0, -1, 0);
    chk("R7 resumed", data, 8'hF6);
    pop1();

    // R8: pop coincides with stop decision on full queue
    send(9'h011, 1'b0, 1'b1, 1'b0, -1, 0);
    send(9'h022, 1'b0, 1'b1, 1'b0, -1, 0);
    send(9'h033, 1'b0, 1'b1, 1'b1, -1, 0);
    chk("R8 no overrun", ovr, 0);
    chk("R8 head", data, 8'h22);
    pop1();
    chk("R8 third stored", data, 8'h33);
    pop1();
    chk("R8 empty", valid, 0);

    // R10: abort by enable low
    for (int s = 0; s < 16; s++) sample(1'b0, 1'b0);
    for (int s = 0; s < 32; s++) sample(1'b1, 1'b0);
    rx = 1'b1;
    toggle_en();
    idle(40);
    chk("R10 aborted frame", valid, 0);
    send(9'h066, 1'b0, 1'b1, 1'b0, -1, 0);
    chk("R10 after abort", data, 8'h66);
    pop1();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule